// File: doc/BRIEF.md
# Windowed Remote Address Translator

This block sits between a local bus and a serial link to a peer device, and it converts addresses in both directions. On the outbound side, one contiguous window in the local address space is aimed at the peer. A local address inside that window has the window base removed, so that the peer receives an address relative to zero. The window is exactly as large as the peer's whole map, which is the sum of the four inbound region sizes.

On the inbound side, addresses that arrive from the peer are split across four regions. The regions are packed one after another in the peer's address space. Each region has its own size and its own local offset, so each can land anywhere in local memory.

A small write/read register file holds the window base and the four size/offset pairs. Both lookups are combinational from the current register contents, and their results are registered once before they reach the outputs.

Top module: `xlat_window_map`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after reset, every configuration register reads 0, both hit outputs are low and both address outputs are 0.
- R2: The register selector `cfg_idx` picks one register. Index 0 is the outbound window base. Index 2k+1 is the size of inbound region k, and index 2k+2 is its offset (k = 0..3). A write with `cfg_wr` high takes effect at the clock edge. `cfg_rdata` returns the selected register combinationally. Indices above 8 read 0, and writes to them change no register.
- R3: The outbound window size is the sum of the four region sizes. An outbound address is a hit exactly when base <= addr < base + size, computed without wrap-around.
- R4: On an outbound hit, the output address is addr - base.
- R5: On an outbound miss, `tx_hit_o` is low and `tx_addr_o` is 0.
- R6: Inbound region k starts at the sum of the sizes of regions 0..k-1. It covers [start_k, start_k + size_k). At most one region matches a given address.
- R7: On an inbound hit in region k, the output address is offset_k + (addr - start_k), taken modulo 2^32.
- R8: A region whose size is 0 matches nothing. The regions after it start where it would have started.
- R9: An inbound address outside every region gives `rx_hit_o` low and `rx_addr_o` 0.
- R10: Each result appears one clock after its input address. A lookup made in the same cycle as a register write uses the register values from before that write.
- R11: The outbound and inbound lookups are independent and are both evaluated every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register selector |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| tx_addr_i | input | 32 | Local address to send to the peer |
| tx_hit_o | output | 1 | Outbound address fell inside the window |
| tx_addr_o | output | 32 | Translated outbound address |
| rx_addr_i | input | 32 | Address received from the peer |
| rx_hit_o | output | 1 | Inbound address fell inside a region |
| rx_addr_o | output | 32 | Translated local address |

## Verification
A region-size write can land in the same cycle as an inbound lookup. The lookup must then resolve against the old region boundaries, and only the following lookup sees the moved boundaries. The bench provokes this by writing region 0's size while it presents an address that changes region under the new size. It judges the two consecutive results against a model that applies each write only after it has predicted that cycle's result. The outbound and inbound lookups run in the same cycle throughout the bench, and each is scored on its own.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int unsigned XL_AW   = 32;
    localparam int unsigned XL_NREG = 4;

    // register selector layout: window base first, then size/offset pairs
    function automatic int unsigned size_sel(input int unsigned k);
        return 2 * k + 1;
    endfunction

    function automatic int unsigned off_sel(input int unsigned k);
        return 2 * k + 2;
    endfunction
endpackage

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
    import xlat_pkg::*;
#(
    parameter int unsigned AW    = XL_AW,
    parameter int unsigned NREG  = XL_NREG,
    parameter int unsigned IDX_W = $clog2(2 * NREG + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [IDX_W-1:0]          idx,
    input  logic [AW-1:0]             wdata,
    output logic [AW-1:0]             rdata,
    output logic [AW-1:0]             base_o,
    output logic [NREG-1:0][AW-1:0]   size_o,
    output logic [NREG-1:0][AW-1:0]   off_o
);
    typedef struct packed {
        logic [AW-1:0]           base;
        logic [NREG-1:0][AW-1:0] size;
        logic [NREG-1:0][AW-1:0] off;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (idx == '0) cfg_d.base = wdata;
            for (int k = 0; k < NREG; k++) begin
                if (idx == IDX_W'(size_sel(k))) cfg_d.size[k] = wdata;
                if (idx == IDX_W'(off_sel(k)))  cfg_d.off[k]  = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (idx == '0) rdata = cfg_q.base;
        for (int k = 0; k < NREG; k++) begin
            if (idx == IDX_W'(size_sel(k))) rdata = cfg_q.size[k];
            if (idx == IDX_W'(off_sel(k)))  rdata = cfg_q.off[k];
        end
    end

    assign base_o = cfg_q.base;
    assign size_o = cfg_q.size;
    assign off_o  = cfg_q.off;

    // R2: a write to the base selector is visible on the next cycle
    assert_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == '0) |=> (base_o == $past(wdata)));
endmodule

// File: rtl/xlat_tx_path.sv
module xlat_tx_path
    import xlat_pkg::*;
#(
    parameter int unsigned AW   = XL_AW,
    parameter int unsigned NREG = XL_NREG,
    parameter int unsigned SW   = AW + $clog2(NREG) + 1
) (
    input  logic [AW-1:0]           addr_i,
    input  logic [AW-1:0]           base_i,
    input  logic [NREG-1:0][AW-1:0] size_i,
    output logic [SW-1:0]           total_o,
    output logic                    hit_o,
    output logic [AW-1:0]           addr_o
);
    logic [AW:0] diff;

    always_comb begin
        total_o = '0;
        for (int k = 0; k < NREG; k++) total_o = total_o + SW'(size_i[k]);
    end

    assign diff   = {1'b0, addr_i} - {1'b0, base_i};
    assign hit_o  = !diff[AW] && (SW'(diff[AW-1:0]) < total_o);
    assign addr_o = hit_o ? diff[AW-1:0] : '0;
endmodule

// File: rtl/xlat_rx_path.sv
module xlat_rx_path
    import xlat_pkg::*;
#(
    parameter int unsigned AW   = XL_AW,
    parameter int unsigned NREG = XL_NREG,
    parameter int unsigned SW   = AW + $clog2(NREG) + 1
) (
    input  logic [AW-1:0]           addr_i,
    input  logic [NREG-1:0][AW-1:0] size_i,
    input  logic [NREG-1:0][AW-1:0] off_i,
    output logic [NREG-1:0]         sel_o,
    output logic                    hit_o,
    output logic [AW-1:0]           addr_o
);
    logic [SW-1:0] start  [NREG+1];
    logic [AW-1:0] mapped [NREG];

    assign start[0] = '0;

    for (genvar k = 0; k < NREG; k++) begin : g_region
        assign start[k+1] = start[k] + SW'(size_i[k]);
        assign sel_o[k]   = (size_i[k] != '0)
                         && (SW'(addr_i) >= start[k])
                         && (SW'(addr_i) <  start[k+1]);
        assign mapped[k]  = off_i[k] + (addr_i - start[k][AW-1:0]);
    end

    always_comb begin
        hit_o  = 1'b0;
        addr_o = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel_o[k]) begin
                hit_o  = 1'b1;
                addr_o = mapped[k];
            end
        end
    end
endmodule

// File: rtl/xlat_window_map.sv
module xlat_window_map
    import xlat_pkg::*;
#(
    parameter int unsigned AW    = XL_AW,
    parameter int unsigned NREG  = XL_NREG,
    parameter int unsigned IDX_W = $clog2(2 * NREG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    input  logic [AW-1:0]    tx_addr_i,
    output logic             tx_hit_o,
    output logic [AW-1:0]    tx_addr_o,
    input  logic [AW-1:0]    rx_addr_i,
    output logic             rx_hit_o,
    output logic [AW-1:0]    rx_addr_o
);
    localparam int unsigned SW = AW + $clog2(NREG) + 1;

    typedef struct packed {
        logic          tx_hit;
        logic [AW-1:0] tx_addr;
        logic          rx_hit;
        logic [AW-1:0] rx_addr;
    } res_t;

    logic [AW-1:0]           base_w;
    logic [NREG-1:0][AW-1:0] size_w, off_w;
    logic [SW-1:0]           tx_total;
    logic                    tx_hit_c, rx_hit_c;
    logic [AW-1:0]           tx_addr_c, rx_addr_c;
    logic [NREG-1:0]         rx_sel;
    res_t                    res_d, res_q;

    xlat_cfg_regs #(.AW(AW), .NREG(NREG), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_idx),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .base_o(base_w), .size_o(size_w), .off_o(off_w)
    );

    xlat_tx_path #(.AW(AW), .NREG(NREG), .SW(SW)) u_tx (
        .addr_i(tx_addr_i), .base_i(base_w), .size_i(size_w),
        .total_o(tx_total), .hit_o(tx_hit_c), .addr_o(tx_addr_c)
    );

    xlat_rx_path #(.AW(AW), .NREG(NREG), .SW(SW)) u_rx (
        .addr_i(rx_addr_i), .size_i(size_w), .off_i(off_w),
        .sel_o(rx_sel), .hit_o(rx_hit_c), .addr_o(rx_addr_c)
    );

    always_comb begin
        res_d.tx_hit  = tx_hit_c;
        res_d.tx_addr = tx_addr_c;
        res_d.rx_hit  = rx_hit_c;
        res_d.rx_addr = rx_addr_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign tx_hit_o  = res_q.tx_hit;
    assign tx_addr_o = res_q.tx_addr;
    assign rx_hit_o  = res_q.rx_hit;
    assign rx_addr_o = res_q.rx_addr;

    // R3: a registered outbound hit lies inside the window as it was sized a cycle earlier
    assert_tx_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit_o |-> (SW'(tx_addr_o) < $past(tx_total)));

    // R5: outbound miss drives a zero address
    assert_tx_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_hit_o |-> (tx_addr_o == '0));

    // R6: packed regions never overlap
    assert_rx_one_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_sel));

    // R9: inbound miss drives a zero address
    assert_rx_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_hit_o |-> (rx_addr_o == '0));
endmodule

// File: tb/xlat_window_map_test.sv
module xlat_window_map_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] tx_addr_i = '0, rx_addr_i = '0;
    logic        tx_hit_o, rx_hit_o;
    logic [31:0] tx_addr_o, rx_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic        txh;
        logic [31:0] txa;
        logic        rxh;
        logic [31:0] rxa;
        string       tag;
    } exp_t;

    exp_t  sbq[$];
    exp_t  e;
    longint m_base;
    longint m_size [4];
    longint m_off  [4];

    xlat_window_map uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_addr_i(tx_addr_i), .tx_hit_o(tx_hit_o), .tx_addr_o(tx_addr_o),
        .rx_addr_i(rx_addr_i), .rx_hit_o(rx_hit_o), .rx_addr_o(rx_addr_o)
    );

    always #10 clk = ~clk;

    function automatic exp_t model(input longint ta, input longint ra, input string tag);
        exp_t   r;
        longint tot = 0;
        longint st  = 0;
        r.tag = tag; r.txh = 0; r.txa = 0; r.rxh = 0; r.rxa = 0;
        for (int k = 0; k < 4; k++) tot += m_size[k];
        if (ta >= m_base && (ta - m_base) < tot) begin
            r.txh = 1; r.txa = 32'(ta - m_base);
        end
        for (int k = 0; k < 4; k++) begin
            if (m_size[k] != 0 && ra >= st && ra < st + m_size[k]) begin
                r.rxh = 1; r.rxa = 32'((m_off[k] + ra - st) & 64'hFFFF_FFFF);
            end
            st += m_size[k];
        end
        return r;
    endfunction

    task automatic drive(input bit wr, input int idx, input longint data,
                         input longint ta, input longint ra, input string tag);
        @(negedge clk);
        cfg_wr = wr; cfg_idx = 4'(idx); cfg_wdata = 32'(data);
        tx_addr_i = 32'(ta); rx_addr_i = 32'(ra);
        sbq.push_back(model(ta, ra, tag));
        if (wr) begin
            if (idx == 0) m_base = data;
            for (int k = 0; k < 4; k++) begin
                if (idx == 2 * k + 1) m_size[k] = data;
                if (idx == 2 * k + 2) m_off[k]  = data;
            end
        end
    endtask

    task automatic check_reg(input int idx, input longint expv, input string tag);
        @(negedge clk);
        cfg_wr = 0; cfg_idx = 4'(idx);
        #1;
        checks++;
        if (cfg_rdata !== 32'(expv)) begin
            errors++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, cfg_rdata, 32'(expv));
        end
    endtask

    // monitor: scores the registered results one edge after each drive
    always begin
        @(posedge clk);
        #5;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (tx_hit_o !== e.txh || tx_addr_o !== e.txa ||
                rx_hit_o !== e.rxh || rx_addr_o !== e.rxa) begin
                errors++;
                $display("FAIL %s: actual tx %b/%h rx %b/%h expected tx %b/%h rx %b/%h",
                         e.tag, tx_hit_o, tx_addr_o, rx_hit_o, rx_addr_o,
                         e.txh, e.txa, e.rxh, e.rxa);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_base = 0;
        for (int k = 0; k < 4; k++) begin m_size[k] = 0; m_off[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs and registers are zero under reset
        checks++;
        if (tx_hit_o !== 0 || tx_addr_o !== 0 || rx_hit_o !== 0 || rx_addr_o !== 0) begin
            errors++;
            $display("FAIL R1: actual tx %b/%h rx %b/%h expected all zero",
                     tx_hit_o, tx_addr_o, rx_hit_o, rx_addr_o);
        end
        for (int i = 0; i < 9; i++) check_reg(i, 0, "R1");
        @(negedge clk) rst_n = 1;
        drive(0, 0, 0, 0, 0, "R1 empty map misses");

        // R2: program window and regions (region 2 left disabled)
        drive(1, 0, 64'h1000_0000, 0, 0, "R2 cfg");
        drive(1, 1, 64'h100,       0, 0, "R2 cfg");
        drive(1, 2, 64'h8000_0000, 0, 0, "R2 cfg");
        drive(1, 3, 64'h200,       0, 0, "R2 cfg");
        drive(1, 4, 64'h4000,      0, 0, "R2 cfg");
        drive(1, 6, 64'h9999,      0, 0, "R2 cfg");
        drive(1, 7, 64'h50,        0, 0, "R2 cfg");
        drive(1, 8, 64'hFFFF_FFF0, 0, 0, "R2 cfg");
        drive(1, 9, 64'hDEAD_BEEF, 0, 0, "R2 bad index");
        @(negedge clk) cfg_wr = 0;
        check_reg(0, 64'h1000_0000, "R2");
        check_reg(3, 64'h200, "R2");
        check_reg(5, 0, "R2");
        check_reg(6, 64'h9999, "R2");
        check_reg(8, 64'hFFFF_FFF0, "R2");
        check_reg(9, 0, "R2 unused index reads zero");
        check_reg(1, 64'h100, "R2 unused write touched nothing");

        // R3 R4 R5 with R9 R6 R7 R8 on the inbound side in the same cycles (R11)
        drive(0, 15, 0, 64'h0FFF_FFFF, 64'h0,   "R5 below base / R6 region0 start");
        drive(0, 15, 0, 64'h1000_0000, 64'hFF,  "R4 base / R7 region0 end");
        drive(0, 15, 0, 64'h1000_034F, 64'h100, "R3 last window word / R6 region1 start");
        drive(0, 15, 0, 64'h1000_0350, 64'h2FF, "R5 one past window / R7 region1 end");
        drive(0, 15, 0, 64'h1000_0123, 64'h300, "R4 inside / R8 region3 follows region1");
        drive(0, 15, 0, 64'hFFFF_FFFF, 64'h34F, "R5 top address / R7 offset wraps");
        drive(0, 15, 0, 64'h1000_0010, 64'h350, "R11 tx hit / R9 rx past all regions");
        drive(0, 15, 0, 64'h0,         64'hFFFF_FFFF, "R5 zero / R9 top address");

        // R10: resize region 0 while looking up; old sizes apply that cycle
        drive(1, 1, 64'h10, 64'h1000_0340, 64'h50, "R10 lookup during write");
        drive(0, 15, 0,     64'h1000_0340, 64'h50, "R10 lookup after write");
        drive(0, 15, 0,     64'h1000_025F, 64'h0F, "R3 shrunk window / R6 region0");
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule